// File: doc/BRIEF.md
# Tiled LUT Nibble Access Window

This block gives a byte-wide processor bus access to the lookup-table contents of an array of logic cells. Each cell keeps two tiles, a low tile and a high tile, and each tile holds eight 4-bit entries. The block decodes a small address window into three views of that storage. One view reaches the low tile, one reaches the high tile, and a packed view reaches the same entry of both tiles in a single byte.

Cells are chosen with a row mask and a column mask. A write goes to every cell whose row bit and column bit are both set. A read returns the data of one cell, picked by a fixed priority. A separate 4-bit pad mask marks accesses aimed at edge pad cells. Pad cells have no lookup table, so any set pad bit blocks writes and forces reads to zero. The full table contents leave the block on a flat storage port, which the cell evaluation logic reads.

Top module: `lut_nibble_window`

## Requirements
- R1: While `rst` is high on a clock edge, every entry of every cell clears to 0 and `bus_rvalid` goes low.
- R2: Offsets 0x38..0x3F reach low-tile entry `addr[2:0]`. A write stores `wdata[3:0]`, and a read returns the entry in bits 3:0 with bits 7:4 at zero.
- R3: Offsets 0x40..0x47 reach high-tile entry `addr[2:0]`. A write stores `wdata[3:0]`, and a read returns the entry in bits 3:0 with bits 7:4 at zero.
- R4: Offsets 0x48..0x4F reach entry `addr[2:0]` of both tiles at once. Bits 7:4 carry the high tile and bits 3:0 carry the low tile, for both reads and writes.
- R5: Any other offset is unused. A read of an unused offset returns 0x00, and a write to one changes no stored entry.
- R6: A write updates every cell at (r,c) with `row_sel[r]` and `col_sel[c]` both set. If either mask is all zero, no cell changes.
- R7: A read uses the cell at the highest set row index and the highest set column index. A mask with no bit set counts as index 0.
- R8: If any bit of `pad_sel` is set, a write changes nothing and a read returns 0x00.
- R9: `bus_rdata` and `bus_rvalid` are registered. `bus_rvalid` is high exactly in the cycle after a cycle with `bus_rd` high, and `bus_rdata` then holds the read result until the next read. A read in the same cycle as a write returns the value from before the write.
- R10: On `lut_q`, cell k = r*COLS + c occupies bits k*64 upward. Low entry e sits at offset 4e, and high entry e sits at offset 32 + 4e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset in the access window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read result valid, one cycle after `bus_rd` |
| row_sel | input | ROWS | Row selection mask |
| col_sel | input | COLS | Column selection mask |
| pad_sel | input | 4 | Pad selection mask (east, west, north, south) |
| lut_q | output | ROWS*COLS*64 | Flat storage contents of all cells |

## Verification
The bench builds the block as a 4 by 4 array. At that size, masks that set several bits in the middle and at the edges of both dimensions are easy to write by hand, and the whole storage port can be compared after every write. It uses overlapping multi-cell masks for the broadcast and priority cases, and empty masks for the fallback to index 0. It also drives a read and a write together in one cycle to show that a read returns the value from before the write.

// File: rtl/lutwin_pkg.sv
package lutwin_pkg;
  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_LO   = 2'd1,
    VIEW_HI   = 2'd2,
    VIEW_BOTH = 2'd3
  } view_e;

  localparam int TILE_ENTRIES = 8;
  localparam int NIB_W        = 4;
  localparam int TILE_BITS    = TILE_ENTRIES * NIB_W;
  localparam int CELL_BITS    = 2 * TILE_BITS;
  localparam int ENTRY_W      = $clog2(TILE_ENTRIES);
endpackage

// File: rtl/lutwin_decode.sv
module lutwin_decode
  import lutwin_pkg::*;
(
  input  logic [7:0]         addr,
  output view_e              view,
  output logic [ENTRY_W-1:0] entry
);
  // Each view spans one aligned group of eight offsets
  always_comb begin
    case (addr[7:3])
      5'h07:   view = VIEW_LO;
      5'h08:   view = VIEW_HI;
      5'h09:   view = VIEW_BOTH;
      default: view = VIEW_NONE;
    endcase
  end

  assign entry = addr[ENTRY_W-1:0];
endmodule

// File: rtl/lutwin_pick.sv
module lutwin_pick #(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    sel,
  output logic [IDXW-1:0] idx
);
  // Highest set bit wins; an empty mask falls back to index 0
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/lutwin_cell.sv
module lutwin_cell
  import lutwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  view_e                view,
  input  logic [ENTRY_W-1:0]   entry,
  input  logic [7:0]           wdata,
  output logic [CELL_BITS-1:0] q
);
  logic [NIB_W-1:0] lo_mem [TILE_ENTRIES];
  logic [NIB_W-1:0] hi_mem [TILE_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < TILE_ENTRIES; e++) begin
        lo_mem[e] <= '0;
        hi_mem[e] <= '0;
      end
    end else if (we) begin
      case (view)
        VIEW_LO:   lo_mem[entry] <= wdata[3:0];
        VIEW_HI:   hi_mem[entry] <= wdata[3:0];
        VIEW_BOTH: begin
          hi_mem[entry] <= wdata[7:4];
          lo_mem[entry] <= wdata[3:0];
        end
        default: ;
      endcase
    end
  end

  for (genvar e = 0; e < TILE_ENTRIES; e++) begin : g_pack
    assign q[e*NIB_W +: NIB_W]             = lo_mem[e];
    assign q[TILE_BITS + e*NIB_W +: NIB_W] = hi_mem[e];
  end
endmodule

// File: rtl/lut_nibble_window.sv
module lut_nibble_window
  import lutwin_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int NCELLS = ROWS * COLS,
  localparam int RIDXW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CIDXW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int KIDXW  = (NCELLS > 1) ? $clog2(NCELLS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [7:0]                  bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [7:0]                  bus_wdata,
  output logic [7:0]                  bus_rdata,
  output logic                        bus_rvalid,
  input  logic [ROWS-1:0]             row_sel,
  input  logic [COLS-1:0]             col_sel,
  input  logic [3:0]                  pad_sel,
  output logic [NCELLS*CELL_BITS-1:0] lut_q
);
  view_e              view;
  logic [ENTRY_W-1:0] entry;
  logic               pad_any;
  logic               wr_ok;
  logic [RIDXW-1:0]   prow;
  logic [CIDXW-1:0]   pcol;
  logic [KIDXW-1:0]   pcell;
  logic [CELL_BITS-1:0] cell_q [NCELLS];
  logic [CELL_BITS-1:0] picked;
  logic [7:0]         rd_next;

  lutwin_decode u_dec (.addr(bus_addr), .view(view), .entry(entry));

  assign pad_any = |pad_sel;
  assign wr_ok   = bus_wr && !pad_any && (view != VIEW_NONE);

  // One storage cell per grid position; write enable is the mask product
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      lutwin_cell u_cell (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_ok && row_sel[r] && col_sel[c]),
        .view (view),
        .entry(entry),
        .wdata(bus_wdata),
        .q    (cell_q[r*COLS + c])
      );
      assign lut_q[(r*COLS + c)*CELL_BITS +: CELL_BITS] = cell_q[r*COLS + c];
    end
  end

  lutwin_pick #(.N(ROWS)) u_prow (.sel(row_sel), .idx(prow));
  lutwin_pick #(.N(COLS)) u_pcol (.sel(col_sel), .idx(pcol));

  assign pcell  = KIDXW'(int'(prow) * COLS + int'(pcol));
  assign picked = cell_q[pcell];

  always_comb begin
    rd_next = 8'h00;
    if (!pad_any) begin
      case (view)
        VIEW_LO:   rd_next = {4'h0, picked[entry*NIB_W +: NIB_W]};
        VIEW_HI:   rd_next = {4'h0, picked[TILE_BITS + entry*NIB_W +: NIB_W]};
        VIEW_BOTH: rd_next = {picked[TILE_BITS + entry*NIB_W +: NIB_W],
                              picked[entry*NIB_W +: NIB_W]};
        default:   rd_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= 8'h00;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end

  // R1: reset clears storage and read strobe
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (lut_q == '0 && !bus_rvalid));

  // R5: unused offsets read as zero and never modify storage
  assert_unused_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && view == VIEW_NONE) |=> bus_rdata == 8'h00);
  assert_unused_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && view == VIEW_NONE) |=> $stable(lut_q));

  // R2/R3: single-tile views leave the upper nibble clear
  assert_tile_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (view == VIEW_LO || view == VIEW_HI)) |=> bus_rdata[7:4] == 4'h0);

  // R8: pad selection blocks writes and zeroes reads
  assert_pad_blocks_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && pad_any) |=> $stable(lut_q));
  assert_pad_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && pad_any) |=> bus_rdata == 8'h00);

  // R6: an empty mask in either dimension writes nothing
  assert_empty_mask_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (row_sel == '0 || col_sel == '0)) |=> $stable(lut_q));

  // R9: valid tracks the read strobe with one cycle of latency
  assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  assert_rvalid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (!bus_rvalid && $stable(bus_rdata)));
endmodule

// File: tb/lut_nibble_window_bench.sv
`timescale 1ns/1ps
module lut_nibble_window_bench;
  localparam int R = 4;
  localparam int C = 4;
  localparam int N = R * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic [R-1:0] row_sel = '0;
  logic [C-1:0] col_sel = '0;
  logic [3:0] pad_sel = '0;
  logic [N*64-1:0] lut_q;

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0] m_lo [N][8];
  logic [3:0] m_hi [N][8];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] last_rd = 8'h00;

  always #2 clk = ~clk;

  lut_nibble_window #(.ROWS(R), .COLS(C)) u_lut_nibble_window (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .row_sel(row_sel), .col_sel(col_sel), .pad_sel(pad_sel), .lut_q(lut_q)
  );

  function automatic int top_bit4(input logic [3:0] s);
    int k = 0;
    for (int i = 3; i >= 0; i--) if (s[i]) begin k = i; break; end
    return k;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    int k = top_bit4(row_sel) * C + top_bit4(col_sel);
    int e = int'(a[2:0]);
    if (pad_sel != 4'h0) return 8'h00;
    case (a[7:3])
      5'h07: return {4'h0, m_lo[k][e]};
      5'h08: return {4'h0, m_hi[k][e]};
      5'h09: return {m_hi[k][e], m_lo[k][e]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [N*64-1:0] model_vec();
    logic [N*64-1:0] v = '0;
    for (int k = 0; k < N; k++)
      for (int e = 0; e < 8; e++) begin
        v[k*64 + 4*e +: 4]      = m_lo[k][e];
        v[k*64 + 32 + 4*e +: 4] = m_hi[k][e];
      end
    return v;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int e = int'(a[2:0]);
    if (pad_sel != 4'h0) return;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        if (row_sel[r] && col_sel[c]) begin
          case (a[7:3])
            5'h07: m_lo[r*C+c][e] = d[3:0];
            5'h08: m_hi[r*C+c][e] = d[3:0];
            5'h09: begin m_hi[r*C+c][e] = d[7:4]; m_lo[r*C+c][e] = d[3:0]; end
            default: ;
          endcase
        end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    exp_q.push_back(exp_rd(a)); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rdwr(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    exp_q.push_back(exp_rd(a)); tag_q.push_back(tag);
    model_write(a, d);
    bus_addr = a; bus_wdata = d; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic check_store(input string tag);
    @(negedge clk);
    n_cmp++;
    if (lut_q !== model_vec()) begin
      n_bad++;
      $display("FAIL %s storage: actual %h expected %h", tag, lut_q, model_vec());
    end
  endtask

  // Scoreboard monitor: pops one expectation per valid read result
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected read result: actual %h expected none", bus_rdata);
      end else begin
        automatic logic [7:0] ev = exp_q.pop_front();
        automatic string tg = tag_q.pop_front();
        last_rd = ev;
        if (bus_rdata !== ev) begin
          n_bad++;
          $display("FAIL %s read: actual %h expected %h", tg, bus_rdata, ev);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++)
      for (int e = 0; e < 8; e++) begin m_lo[k][e] = '0; m_hi[k][e] = '0; end

    repeat (3) @(negedge clk);
    // R1: state while held in reset
    n_cmp++;
    if (bus_rvalid !== 1'b0 || lut_q !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: actual rvalid=%b store=%h expected 0", bus_rvalid, lut_q);
    end
    rst = 1'b0;
    rd(8'h38, "R1");

    // R2, R3, R4, R10 on a single cell
    row_sel = 4'b0001; col_sel = 4'b0001;
    wr(8'h3A, 8'hF5);
    check_store("R10");
    rd(8'h3A, "R2");
    wr(8'h45, 8'h9C);
    rd(8'h45, "R3");
    rd(8'h4D, "R4");
    wr(8'h4F, 8'hA7);
    rd(8'h3F, "R2");
    rd(8'h47, "R3");
    rd(8'h4F, "R4");
    check_store("R4");

    // R5: unused offsets
    wr(8'h30, 8'hFF);
    wr(8'h37, 8'hFF);
    wr(8'h50, 8'hFF);
    wr(8'h6F, 8'hFF);
    check_store("R5");
    rd(8'h37, "R5");
    rd(8'h50, "R5");

    // R6: broadcast to a multi-cell selection, then empty masks
    row_sel = 4'b0110; col_sel = 4'b1010;
    wr(8'h48, 8'h3E);
    check_store("R6");
    row_sel = 4'b0000; col_sel = 4'b1111;
    wr(8'h49, 8'h11);
    row_sel = 4'b1111; col_sel = 4'b0000;
    wr(8'h42, 8'h0D);
    check_store("R6");

    // R7: priority among several selected cells
    row_sel = 4'b0100; col_sel = 4'b1000;
    wr(8'h48, 8'h55);
    row_sel = 4'b0010; col_sel = 4'b0010;
    wr(8'h48, 8'h22);
    row_sel = 4'b0110; col_sel = 4'b1010;
    rd(8'h48, "R7");
    row_sel = 4'b0001; col_sel = 4'b0001;
    wr(8'h48, 8'h77);
    row_sel = 4'b0000; col_sel = 4'b0000;
    rd(8'h48, "R7");
    row_sel = 4'b1001; col_sel = 4'b0000;
    rd(8'h4F, "R7");

    // R8: pad mask inhibit
    row_sel = 4'b0001; col_sel = 4'b0001; pad_sel = 4'b0100;
    wr(8'h48, 8'hEE);
    check_store("R8");
    rd(8'h48, "R8");
    pad_sel = 4'b1000;
    wr(8'h3B, 8'h06);
    check_store("R8");
    pad_sel = 4'b0000;
    rd(8'h48, "R8");

    // R9: read and write in the same cycle, then idle behaviour
    rdwr(8'h48, 8'h99, "R9");
    rd(8'h48, "R9");
    @(negedge clk);
    n_cmp++;
    if (bus_rvalid !== 1'b0 || bus_rdata !== last_rd) begin
      n_bad++;
      $display("FAIL R9 idle: actual rvalid=%b rdata=%h expected 0 %h",
               bus_rvalid, bus_rdata, last_rd);
    end
    check_store("R10");

    repeat (3) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9 missing results: actual %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule